// File: doc/BRIEF.md
# Register Dependency Hazard Classifier

This block looks at a small window of decoded register-to-register instructions, held in program order in fixed slots, and finds every ordering hazard between them. Each slot carries a valid bit, one destination register number and two source register numbers. For each ordered pair of slots (older, younger) the block raises three separate flags. The first marks a flow hazard: the younger instruction reads what the older one writes. The second marks an output hazard: both instructions write the same register. The third marks an antidependency: the younger instruction overwrites a register the older one still has to read. The block compares only architectural register numbers. It holds no register values and does not look at memory addresses.

The block also produces a per-slot "may execute now" bit for a simple in-order issue stage with two pipelines. A slot may go if it is valid and no older slot has a flow hazard into it. Every older valid slot must also be going, and fewer than two older slots may already have been picked. Invalid slots are holes in the window: they are skipped and block nothing. All outputs are registered, so the results for a window appear one clock after the window is sampled. Issue logic uses the block by presenting a new window each cycle.

Top module: `hzd_classifier`

## Requirements
- R1: Pair flag `raw_q` is set when both slots are valid and the older slot's destination equals either source of the younger slot.
- R2: Pair flag `waw_q` is set when both slots are valid and their destinations are equal. This includes an instruction that reads and writes a register followed by one that writes it again.
- R3: Pair flag `war_q` is set when both slots are valid and the younger slot's destination equals either source of the older slot.
- R4: A pair with either slot invalid has all three flags clear, whatever its register fields hold.
- R5: Register number 0 is compared like any other register number and has no special meaning.
- R6: All outputs are registered and show the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.
- R7: The flag of pair (older o, younger y) sits at bit y*(y-1)/2+o. With 4 slots the order is (0,1),(0,2),(1,2),(0,3),(1,3),(2,3). Slot i occupies bits [4i+3:4i] of each register field bus.
- R8: `exec_q[i]` is 0 when slot i is invalid or any older valid slot has a flow hazard into it.
- R9: `exec_q[i]` is 1 only if every older valid slot also has its `exec_q` bit set. Invalid older slots do not block.
- R10: Slots are taken lowest first, and at most two `exec_q` bits are set at a time. Four valid independent slots give `exec_q` = 4'b0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 4 | Valid bit per slot, bit 0 is the oldest slot |
| in_dst | input | 16 | Destination register number per slot |
| in_srca | input | 16 | First source register number per slot |
| in_srcb | input | 16 | Second source register number per slot |
| raw_q | output | 6 | Flow hazard flag per ordered pair |
| waw_q | output | 6 | Output hazard flag per ordered pair |
| war_q | output | 6 | Antidependency flag per ordered pair |
| exec_q | output | 4 | May-execute-now bit per slot |

## Verification
Every result (the eighteen pair flags and the four issue bits) depends only on the window sampled at one rising edge. Each result is due exactly one clock after that edge. The driver applies a window on a falling edge and queues the expected result. The monitor takes that item off the queue 2 ns after the next rising edge and compares all four outputs, so every comparison falls one register stage after its stimulus. Windows follow each other every cycle, so a result arriving a cycle late or early shows up as a mismatch with a neighbouring window.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // number of ordered (older, younger) pairs among n slots
  function automatic int num_pairs(input int n);
    return n * (n - 1) / 2;
  endfunction

  // bit position of pair (older o, younger y), o < y
  function automatic int pair_idx(input int o, input int y);
    return y * (y - 1) / 2 + o;
  endfunction

endpackage

// File: rtl/hzd_pair_cmp.sv
module hzd_pair_cmp #(
  parameter int RIDX_W = 4
) (
  input  logic              old_vld,
  input  logic [RIDX_W-1:0] old_dst,
  input  logic [RIDX_W-1:0] old_sa,
  input  logic [RIDX_W-1:0] old_sb,
  input  logic              yng_vld,
  input  logic [RIDX_W-1:0] yng_dst,
  input  logic [RIDX_W-1:0] yng_sa,
  input  logic [RIDX_W-1:0] yng_sb,
  output logic              raw,
  output logic              waw,
  output logic              war
);

  // true when register r is one of the two sources
  function automatic logic reads_reg(input logic [RIDX_W-1:0] a,
                                     input logic [RIDX_W-1:0] b,
                                     input logic [RIDX_W-1:0] r);
    return (a == r) || (b == r);
  endfunction

  logic both_vld;
  assign both_vld = old_vld & yng_vld;

  assign raw = both_vld & reads_reg(yng_sa, yng_sb, old_dst);
  assign waw = both_vld & (old_dst == yng_dst);
  assign war = both_vld & reads_reg(old_sa, old_sb, yng_dst);

endmodule

// File: rtl/hzd_issue_sel.sv
module hzd_issue_sel #(
  parameter int SLOTS   = 4,
  parameter int ISSUE_W = 2
) (
  input  logic [SLOTS-1:0] vld,
  input  logic [SLOTS-1:0] raw_into,
  output logic [SLOTS-1:0] exec_ok
);

  localparam int CW = $clog2(SLOTS + 1);

  logic [CW-1:0] taken;
  logic          stalled;

  always_comb begin
    exec_ok = '0;
    taken   = '0;
    stalled = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i]) begin
        if (!stalled && !raw_into[i] && (taken < CW'(ISSUE_W))) begin
          exec_ok[i] = 1'b1;
          taken      = taken + 1'b1;
        end else begin
          stalled = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hzd_classifier.sv
module hzd_classifier #(
  parameter int SLOTS   = 4,
  parameter int RIDX_W  = 4,
  parameter int ISSUE_W = 2,
  localparam int NPAIRS = hzd_pkg::num_pairs(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        in_vld,
  input  logic [SLOTS*RIDX_W-1:0] in_dst,
  input  logic [SLOTS*RIDX_W-1:0] in_srca,
  input  logic [SLOTS*RIDX_W-1:0] in_srcb,
  output logic [NPAIRS-1:0]       raw_q,
  output logic [NPAIRS-1:0]       waw_q,
  output logic [NPAIRS-1:0]       war_q,
  output logic [SLOTS-1:0]        exec_q
);

  logic [NPAIRS-1:0] raw_c;
  logic [NPAIRS-1:0] waw_c;
  logic [NPAIRS-1:0] war_c;
  logic [SLOTS-1:0]  raw_into;
  logic [SLOTS-1:0]  exec_c;

  // one comparator per ordered pair
  for (genvar y = 1; y < SLOTS; y++) begin : g_yng
    for (genvar o = 0; o < y; o++) begin : g_old
      localparam int P  = hzd_pkg::pair_idx(o, y);
      localparam int OB = o * RIDX_W;
      localparam int YB = y * RIDX_W;

      hzd_pair_cmp #(.RIDX_W(RIDX_W)) u_cmp (
        .old_vld (in_vld[o]),
        .old_dst (in_dst[OB +: RIDX_W]),
        .old_sa  (in_srca[OB +: RIDX_W]),
        .old_sb  (in_srcb[OB +: RIDX_W]),
        .yng_vld (in_vld[y]),
        .yng_dst (in_dst[YB +: RIDX_W]),
        .yng_sa  (in_srca[YB +: RIDX_W]),
        .yng_sb  (in_srcb[YB +: RIDX_W]),
        .raw     (raw_c[P]),
        .waw     (waw_c[P]),
        .war     (war_c[P])
      );

      // R4: a pair with an invalid member reports nothing
      a_r4_invalid_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_vld[o]) || !$past(in_vld[y])) |-> !(raw_q[P] || waw_q[P] || war_q[P]));

      // R2: output hazard only on matching destinations
      a_r2_waw_same_dst: assert property (@(posedge clk) disable iff (!rst_n)
        waw_q[P] |-> ($past(in_dst[OB +: RIDX_W]) == $past(in_dst[YB +: RIDX_W])));
    end
  end

  // flow hazard into each slot from any older slot
  always_comb begin
    raw_into = '0;
    for (int y = 1; y < SLOTS; y++) begin
      for (int o = 0; o < y; o++) begin
        if (raw_c[hzd_pkg::pair_idx(o, y)]) raw_into[y] = 1'b1;
      end
    end
  end

  hzd_issue_sel #(.SLOTS(SLOTS), .ISSUE_W(ISSUE_W)) u_issue (
    .vld      (in_vld),
    .raw_into (raw_into),
    .exec_ok  (exec_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      waw_q  <= '0;
      war_q  <= '0;
      exec_q <= '0;
    end else begin
      raw_q  <= raw_c;
      waw_q  <= waw_c;
      war_q  <= war_c;
      exec_q <= exec_c;
    end
  end

  // R10: issue width cap
  a_r10_issue_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exec_q) <= ISSUE_W);

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    // R8: only valid, unblocked slots may go
    a_r8_exec_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      exec_q[i] |-> $past(in_vld[i]));
    a_r8_raw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      exec_q[i] |-> !$past(raw_into[i]));
    for (genvar j = 0; j < i; j++) begin : g_older
      // R9: in-order issue
      a_r9_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q[i] && $past(in_vld[j])) |-> exec_q[j]);
    end
  end

endmodule

// File: tb/hzd_classifier_tb_top.sv
module hzd_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_vld = '0;
  logic [15:0] in_dst = '0;
  logic [15:0] in_srca = '0;
  logic [15:0] in_srcb = '0;
  logic [5:0]  raw_q, waw_q, war_q;
  logic [3:0]  exec_q;

  always #5 clk = ~clk;

  hzd_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb),
    .raw_q(raw_q), .waw_q(waw_q), .war_q(war_q), .exec_q(exec_q)
  );

  typedef struct {
    logic [5:0] raw, waw, war;
    logic [3:0] ex;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   ended = 0;

  function automatic logic [3:0] nib(input logic [15:0] bus, input int i);
    return bus[i*4 +: 4];
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(input string tag, input logic [3:0] v,
                                 input logic [15:0] d, input logic [15:0] a,
                                 input logic [15:0] b);
    exp_t e;
    int   k = 0;
    int   picked = 0;
    bit   halt = 0;
    logic [3:0] blk = '0;
    e.raw = '0; e.waw = '0; e.war = '0; e.ex = '0; e.tag = tag;
    for (int y = 1; y < 4; y++) begin
      for (int o = 0; o < y; o++) begin
        if (v[o] && v[y]) begin
          e.raw[k] = (nib(d, o) == nib(a, y)) || (nib(d, o) == nib(b, y));
          e.waw[k] = (nib(d, o) == nib(d, y));
          e.war[k] = (nib(d, y) == nib(a, o)) || (nib(d, y) == nib(b, o));
          if (e.raw[k]) blk[y] = 1'b1;
        end
        k++;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (v[i]) begin
        if (!halt && !blk[i] && picked < 2) begin
          e.ex[i] = 1'b1;
          picked++;
        end else halt = 1;
      end
    end
    return e;
  endfunction

  task automatic check(input string req, input string tag,
                       input logic [5:0] act, input logic [5:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s [%s] actual=%b expected=%b", req, tag, act, expv);
    end
  endtask

  task automatic drive(input string tag, input logic [3:0] v, input logic [15:0] d,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_vld = v; in_dst = d; in_srca = a; in_srcb = b;
    exp_q.push_back(model(tag, v, d, a, b));
  endtask

  // monitor: one result per clock, one register stage after its window (R6)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check("R1", e.tag, raw_q, e.raw);
        check("R2", e.tag, waw_q, e.waw);
        check("R3", e.tag, war_q, e.war);
        check("R8", e.tag, {2'b00, exec_q}, {2'b00, e.ex});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a;
    repeat (3) @(negedge clk);
    // R6: reset state
    in_vld = 4'hF; in_dst = 16'h1111; in_srca = 16'h1111; in_srcb = 16'h1111;
    @(posedge clk); #2;
    check("R6", "reset raw", raw_q, '0);
    check("R6", "reset waw", waw_q, '0);
    check("R6", "reset war", war_q, '0);
    check("R6", "reset exec", {2'b00, exec_q}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    in_vld = '0;

    // example sequence: slot order 0..3, fields {s3,s2,s1,s0}
    drive("R1 R2 R3 example", 4'hF, 16'h7343, 16'h3533, 16'h4535);
    // read-modify-write then rewrite
    drive("R2 rmw pair", 4'b0011, 16'h0011, 16'h0011, 16'h0032);
    // R4: holes in the window
    drive("R4 holes", 4'b0101, 16'h2222, 16'h2222, 16'h2222);
    drive("R4 empty", 4'b0000, 16'h2222, 16'h2222, 16'h2222);
    drive("R4 lone", 4'b1000, 16'h5555, 16'h5555, 16'h5555);
    // R5: register 0 is ordinary
    drive("R5 reg0 flow", 4'b0011, 16'h0090, 16'h0003, 16'h0004);
    drive("R5 reg0 dst", 4'b0011, 16'h0000, 16'h0012, 16'h0034);
    // R7: one flow hazard at each pair position
    for (int y = 1; y < 4; y++) begin
      for (int o = 0; o < y; o++) begin
        d = 16'hBA98;
        a = 16'h3210;
        a[y*4 +: 4] = 4'(8 + o);
        drive($sformatf("R7 pair o%0d y%0d", o, y), 4'hF, d, a, 16'h3210);
      end
    end
    // R10: four independent slots
    drive("R10 cap", 4'hF, 16'hBA98, 16'h3210, 16'h3210);
    drive("R10 three", 4'b1110, 16'hBA98, 16'h3210, 16'h3210);
    // R9: in-order blocking and hole skipping
    drive("R9 blocked", 4'hF, 16'hBA98, 16'h3280, 16'h3210);
    drive("R9 hole first", 4'b1110, 16'hBA98, 16'h3210, 16'h3210);
    drive("R9 late raw", 4'hF, 16'hBA98, 16'h9210, 16'h3210);
    // mixed windows
    for (int n = 0; n < 40; n++) begin
      drive($sformatf("R6 mix %0d", n), 4'($urandom), 16'($urandom & 16'h3333),
            16'($urandom & 16'h3333), 16'($urandom & 16'h3333));
    end
    @(negedge clk);
    in_vld = '0;
    repeat (3) @(posedge clk);
    #3;
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule